// File: doc/BRIEF.md
# Dual-Byte Bidirectional Registered Transceiver

This block moves data between an A port and a B port through storage registers, one register per direction. The data path is split into byte-wide halves, and each half is controlled on its own. In each half and each direction there is a private rising-edge clock, an active-low capture enable and an active-low output enable. When every half receives the same controls, the block acts as one full-width transceiver. When the controls differ, each half serves a separate byte lane.

Each port is modelled as separate signals so that no bidirectional net is needed:

- a data input plus a flag saying whether something outside is driving the port;
- the data the block itself drives, plus its drive enable;
- a resolved bus level, which shows what a wire would carry.

An optional keeper (bus-hold) makes an undriven port keep the last level that was driven onto it. The registers capture the resolved level of the opposite port. Because of this, a value held by the keeper, or a value the block drives itself, can be loaded back across.

A flag reports contention when the block drives a port that something outside is also driving. A synchronous active-low reset clears the registers. It exists only so that simulation starts from a known state.

Top module: `dbyte_reg_xcvr`

## Requirements
- R1: Each half of `HALF_W` bits (half h covers bits h*HALF_W upward) has its own controls, and clocking one half never changes another half. Giving all halves the same controls moves the full `NUM_HALVES*HALF_W`-bit word in one edge.
- R2: On a rising edge of `ab_clk[h]` with `ab_ce_n[h]` low and `rst_n` high, the A-to-B register of half h loads that half's slice of `a_bus`.
- R3: With `ab_ce_n[h]` high, rising edges leave the A-to-B register unchanged. With `ab_ce_n[h]` low and no rising edge, the register is also unchanged whatever `a_bus` does.
- R4: While `ab_oe_n[h]` is low, `b_oe[h]` is 1 and the half's slice of `b_bus` equals the A-to-B register. While it is high, `b_oe[h]` is 0 (high impedance) and `b_bus` shows the external level or the kept level.
- R5: The B-to-A direction behaves the same way. It uses `ba_clk`, `ba_ce_n` and `ba_oe_n`, loads from `b_bus`, and drives `a_out`/`a_oe`/`a_bus`.
- R6: The two registers of a half are separate storage. Loading the B-to-A register leaves the A-to-B register unchanged, and the reverse also holds.
- R7: With `HOLD_EN`=1, a port slice that neither side drives keeps, on its bus output, the last level that was driven onto it. With `HOLD_EN`=0 it reads as unknown.
- R8: A rising edge of a register's own clock while `rst_n` is low clears that register to zero. This happens regardless of its capture enable, and registers on clocks that do not tick keep their value.
- R9: `a_contend[h]` is 1 exactly when the block drives A in half h (`a_oe[h]`=1) while `a_ext_drv[h]` is 1. `b_contend` behaves the same way for B.
- R10: Under contention the bus output shows the block's own driven value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low register clear |
| ab_clk | input | NUM_HALVES | Per-half A-to-B capture clock |
| ab_ce_n | input | NUM_HALVES | Per-half A-to-B capture enable, active low |
| ab_oe_n | input | NUM_HALVES | Per-half B-side drive enable, active low |
| ba_clk | input | NUM_HALVES | Per-half B-to-A capture clock |
| ba_ce_n | input | NUM_HALVES | Per-half B-to-A capture enable, active low |
| ba_oe_n | input | NUM_HALVES | Per-half A-side drive enable, active low |
| a_in | input | NUM_HALVES*HALF_W | Level driven onto A by external logic |
| a_ext_drv | input | NUM_HALVES | Per-half flag: external logic drives A |
| a_out | output | NUM_HALVES*HALF_W | B-to-A register contents offered to A |
| a_oe | output | NUM_HALVES | Per-half: block drives A |
| a_bus | output | NUM_HALVES*HALF_W | Resolved A level |
| a_contend | output | NUM_HALVES | Per-half A drive conflict |
| b_in | input | NUM_HALVES*HALF_W | Level driven onto B by external logic |
| b_ext_drv | input | NUM_HALVES | Per-half flag: external logic drives B |
| b_out | output | NUM_HALVES*HALF_W | A-to-B register contents offered to B |
| b_oe | output | NUM_HALVES | Per-half: block drives B |
| b_bus | output | NUM_HALVES*HALF_W | Resolved B level |
| b_contend | output | NUM_HALVES | Per-half B drive conflict |

## Verification
The bench builds the block with its default parameters: two halves of eight bits and the keeper enabled. With two halves, one half can be clocked, enabled or driven while the other stays still, so byte-lane independence can be observed at the ports. The keeper being on means a released port holds a defined level. That level can be read on the bus and loaded across by the opposite register, which exercises the retained level as real data. The unknown read-back of the keeper-less variant is therefore not reached.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
   localparam int unsigned DBX_HALF_W_DEF  = 8;
   localparam int unsigned DBX_HALVES_DEF  = 2;
   localparam bit          DBX_HOLD_DEF    = 1'b1;

   // low bit index of a half inside the full word
   function automatic int unsigned dbx_lo(input int unsigned half, input int unsigned w);
      return half * w;
   endfunction
endpackage

// File: rtl/dbx_dir_reg.sv
module dbx_dir_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ce_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (!ce_n)
         q <= d;
   end
endmodule

// File: rtl/dbx_port_view.sv
module dbx_port_view #(
   parameter int unsigned W       = 8,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic         own_en,
   input  logic [W-1:0] own_val,
   input  logic         ext_en,
   input  logic [W-1:0] ext_val,
   output logic [W-1:0] bus,
   output logic         contend
);
   logic         driven;
   logic [W-1:0] drv_val;

   assign driven  = own_en | ext_en;
   assign drv_val = own_en ? own_val : ext_val;
   assign contend = own_en & ext_en;

   generate
      if (HOLD_EN) begin : g_keeper
         logic [W-1:0] kept;
         always_latch begin
            if (driven)
               kept <= drv_val;
         end
         assign bus = driven ? drv_val : kept;
      end else begin : g_float
         assign bus = driven ? drv_val : {W{1'bx}};
      end
   endgenerate
endmodule

// File: rtl/dbx_half.sv
module dbx_half #(
   parameter int unsigned W       = 8,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic         rst_n,
   input  logic         ab_clk,
   input  logic         ab_ce_n,
   input  logic         ab_oe_n,
   input  logic         ba_clk,
   input  logic         ba_ce_n,
   input  logic         ba_oe_n,
   input  logic [W-1:0] a_in,
   input  logic         a_ext_drv,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] a_bus,
   output logic         a_contend,
   input  logic [W-1:0] b_in,
   input  logic         b_ext_drv,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   output logic [W-1:0] b_bus,
   output logic         b_contend
);
   logic [W-1:0] ab_q;
   logic [W-1:0] ba_q;

   dbx_dir_reg #(.W(W)) u_ab_reg (
      .clk(ab_clk), .rst_n(rst_n), .ce_n(ab_ce_n), .d(a_bus), .q(ab_q));

   dbx_dir_reg #(.W(W)) u_ba_reg (
      .clk(ba_clk), .rst_n(rst_n), .ce_n(ba_ce_n), .d(b_bus), .q(ba_q));

   assign a_oe  = ~ba_oe_n;
   assign b_oe  = ~ab_oe_n;
   assign a_out = ba_q;
   assign b_out = ab_q;

   dbx_port_view #(.W(W), .HOLD_EN(HOLD_EN)) u_a_view (
      .own_en(a_oe), .own_val(ba_q), .ext_en(a_ext_drv), .ext_val(a_in),
      .bus(a_bus), .contend(a_contend));

   dbx_port_view #(.W(W), .HOLD_EN(HOLD_EN)) u_b_view (
      .own_en(b_oe), .own_val(ab_q), .ext_en(b_ext_drv), .ext_val(b_in),
      .bus(b_bus), .contend(b_contend));
endmodule

// File: rtl/dbyte_reg_xcvr.sv
module dbyte_reg_xcvr
   import dbx_pkg::*;
#(
   parameter int unsigned HALF_W     = DBX_HALF_W_DEF,
   parameter int unsigned NUM_HALVES = DBX_HALVES_DEF,
   parameter bit          HOLD_EN    = DBX_HOLD_DEF,
   localparam int unsigned DW        = HALF_W * NUM_HALVES
) (
   input  logic                  rst_n,
   input  logic [NUM_HALVES-1:0] ab_clk,
   input  logic [NUM_HALVES-1:0] ab_ce_n,
   input  logic [NUM_HALVES-1:0] ab_oe_n,
   input  logic [NUM_HALVES-1:0] ba_clk,
   input  logic [NUM_HALVES-1:0] ba_ce_n,
   input  logic [NUM_HALVES-1:0] ba_oe_n,
   input  logic [DW-1:0]         a_in,
   input  logic [NUM_HALVES-1:0] a_ext_drv,
   output logic [DW-1:0]         a_out,
   output logic [NUM_HALVES-1:0] a_oe,
   output logic [DW-1:0]         a_bus,
   output logic [NUM_HALVES-1:0] a_contend,
   input  logic [DW-1:0]         b_in,
   input  logic [NUM_HALVES-1:0] b_ext_drv,
   output logic [DW-1:0]         b_out,
   output logic [NUM_HALVES-1:0] b_oe,
   output logic [DW-1:0]         b_bus,
   output logic [NUM_HALVES-1:0] b_contend
);
   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("dbyte_reg_xcvr: HALF_W must be at least 1");
      end
      if (NUM_HALVES < 1) begin : g_bad_count
         $error("dbyte_reg_xcvr: NUM_HALVES must be at least 1");
      end
   endgenerate

   genvar h;
   generate
      for (h = 0; h < NUM_HALVES; h++) begin : g_half
         localparam int unsigned LO = dbx_lo(h, HALF_W);
         dbx_half #(.W(HALF_W), .HOLD_EN(HOLD_EN)) u_half (
            .rst_n    (rst_n),
            .ab_clk   (ab_clk[h]),
            .ab_ce_n  (ab_ce_n[h]),
            .ab_oe_n  (ab_oe_n[h]),
            .ba_clk   (ba_clk[h]),
            .ba_ce_n  (ba_ce_n[h]),
            .ba_oe_n  (ba_oe_n[h]),
            .a_in     (a_in[LO +: HALF_W]),
            .a_ext_drv(a_ext_drv[h]),
            .a_out    (a_out[LO +: HALF_W]),
            .a_oe     (a_oe[h]),
            .a_bus    (a_bus[LO +: HALF_W]),
            .a_contend(a_contend[h]),
            .b_in     (b_in[LO +: HALF_W]),
            .b_ext_drv(b_ext_drv[h]),
            .b_out    (b_out[LO +: HALF_W]),
            .b_oe     (b_oe[h]),
            .b_bus    (b_bus[LO +: HALF_W]),
            .b_contend(b_contend[h])
         );
      end
   endgenerate
endmodule

// File: rtl/dbyte_reg_xcvr_sva.sv
module dbyte_reg_xcvr_sva #(
   parameter int unsigned HALF_W     = 8,
   parameter int unsigned NUM_HALVES = 2,
   localparam int unsigned DW        = HALF_W * NUM_HALVES
) (
   input logic                  rst_n,
   input logic [NUM_HALVES-1:0] ab_clk,
   input logic [NUM_HALVES-1:0] ab_ce_n,
   input logic [NUM_HALVES-1:0] ab_oe_n,
   input logic [NUM_HALVES-1:0] ba_clk,
   input logic [NUM_HALVES-1:0] ba_ce_n,
   input logic [NUM_HALVES-1:0] ba_oe_n,
   input logic [DW-1:0]         a_out,
   input logic [DW-1:0]         b_out,
   input logic [DW-1:0]         a_bus,
   input logic [DW-1:0]         b_bus,
   input logic [NUM_HALVES-1:0] a_oe,
   input logic [NUM_HALVES-1:0] b_oe,
   input logic [NUM_HALVES-1:0] a_contend,
   input logic [NUM_HALVES-1:0] b_contend
);
   genvar h;
   generate
      for (h = 0; h < NUM_HALVES; h++) begin : g_chk
         localparam int unsigned LO = h * HALF_W;

         p_load_ab_r2: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
            !ab_ce_n[h] |=> b_out[LO +: HALF_W] == $past(a_bus[LO +: HALF_W]));

         p_hold_ab_r3: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
            ab_ce_n[h] |=> $stable(b_out[LO +: HALF_W]));

         p_load_ba_r5: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
            !ba_ce_n[h] |=> a_out[LO +: HALF_W] == $past(b_bus[LO +: HALF_W]));

         p_hold_ba_r5: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
            ba_ce_n[h] |=> $stable(a_out[LO +: HALF_W]));

         always_comb begin
            if (!ab_oe_n[h])
               p_b_own_drive_r10: assert (b_bus[LO +: HALF_W] == b_out[LO +: HALF_W]);
            if (!ba_oe_n[h])
               p_a_own_drive_r10: assert (a_bus[LO +: HALF_W] == a_out[LO +: HALF_W]);
            if (a_contend[h])
               p_a_contend_r9: assert (a_oe[h]);
            if (b_contend[h])
               p_b_contend_r9: assert (b_oe[h]);
         end
      end
   endgenerate
endmodule

bind dbyte_reg_xcvr dbyte_reg_xcvr_sva #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_sva (
   .rst_n(rst_n), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
   .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
   .a_out(a_out), .b_out(b_out), .a_bus(a_bus), .b_bus(b_bus),
   .a_oe(a_oe), .b_oe(b_oe), .a_contend(a_contend), .b_contend(b_contend));

// File: tb/dbyte_reg_xcvr_tb_top.sv
module dbyte_reg_xcvr_tb_top;
   localparam int unsigned HW = 8;
   localparam int unsigned NH = 2;
   localparam int unsigned DW = HW * NH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [NH-1:0] ab_clk = '0, ab_ce_n = '1, ab_oe_n = '1;
   logic [NH-1:0] ba_clk = '0, ba_ce_n = '1, ba_oe_n = '1;
   logic [DW-1:0] a_in = '0, b_in = '0;
   logic [NH-1:0] a_ext_drv = '0, b_ext_drv = '0;
   logic [DW-1:0] a_out, a_bus, b_out, b_bus;
   logic [NH-1:0] a_oe, a_contend, b_oe, b_contend;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dbyte_reg_xcvr #(.HALF_W(HW), .NUM_HALVES(NH), .HOLD_EN(1'b1)) dut_i (
      .rst_n(rst_n), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
      .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
      .a_in(a_in), .a_ext_drv(a_ext_drv), .a_out(a_out), .a_oe(a_oe),
      .a_bus(a_bus), .a_contend(a_contend),
      .b_in(b_in), .b_ext_drv(b_ext_drv), .b_out(b_out), .b_oe(b_oe),
      .b_bus(b_bus), .b_contend(b_contend));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [NH-1:0] ab, input logic [NH-1:0] ba);
      #2;
      ab_clk = ab;
      ba_clk = ba;
      #5;
      ab_clk = '0;
      ba_clk = '0;
      #3;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      pulse('1, '1);
      rst_n = 1'b1;
      ab_oe_n = '0; ba_oe_n = '0; #1;
      chk("R8 b_bus after reset", b_bus, 16'h0000);
      chk("R8 a_bus after reset", a_bus, 16'h0000);
      chk("R4 b_oe with drive on", b_oe, 2'b11);
      ab_oe_n = '1; ba_oe_n = '1; #1;
   endtask

   task automatic t_load_ab();
      a_ext_drv = 2'b11; a_in = 16'h5A3C; ab_ce_n = 2'b10;
      pulse(2'b01, 2'b00);
      ab_oe_n = 2'b00; #1;
      chk("R2/R1 lower half loads, upper untouched", b_bus, 16'h003C);
   endtask

   task automatic t_hold_ab();
      ab_ce_n = 2'b11; a_in = 16'h1111;
      pulse(2'b11, 2'b00); #1;
      chk("R3 enable high holds through edge", b_bus, 16'h003C);
      ab_ce_n = 2'b10; a_in = 16'h2222; #4;
      chk("R3 enable low without edge holds", b_bus, 16'h003C);
      ab_ce_n = 2'b11;
   endtask

   task automatic t_hiz();
      ab_oe_n = 2'b01; #1;
      chk("R4 lower half released", b_oe, 2'b10);
      b_ext_drv = 2'b01; b_in = 16'h9977; #1;
      chk("R4 released slice shows external level", b_bus, 16'h0077);
   endtask

   task automatic t_keeper_b();
      b_ext_drv = 2'b00; b_in = 16'h4444; #1;
      chk("R7 B keeps last driven level", b_bus, 16'h0077);
   endtask

   task automatic t_load_ba();
      ba_ce_n = 2'b10;
      pulse(2'b00, 2'b01);
      ba_ce_n = 2'b11;
      ba_oe_n = 2'b10; a_ext_drv = 2'b10; #1;
      chk("R5 B-to-A loads kept level", a_bus, 16'h2277);
      chk("R9 no contention", a_contend, 2'b00);
      ab_oe_n = 2'b00; #1;
      chk("R6 A-to-B register untouched", b_bus, 16'h003C);
   endtask

   task automatic t_contend();
      a_ext_drv = 2'b11; #1;
      chk("R9 A contention lower half", a_contend, 2'b01);
      chk("R10 own value wins on bus", a_bus, 16'h2277);
      chk("R9 B side quiet", b_contend, 2'b00);
   endtask

   task automatic t_full_width();
      ba_oe_n = 2'b11; ab_ce_n = 2'b00; a_in = 16'hBEEF;
      pulse(2'b11, 2'b00); #1;
      chk("R1 tied controls move full word", b_bus, 16'hBEEF);
   endtask

   task automatic t_keeper_a();
      a_ext_drv = 2'b00; a_in = 16'h0000; #1;
      chk("R7 A keeps last driven level", a_bus, 16'hBEEF);
      ab_ce_n = 2'b00; a_in = 16'h1234;
      pulse(2'b11, 2'b00); #1;
      chk("R2/R7 kept level loads across", b_bus, 16'hBEEF);
      ab_ce_n = 2'b11;
   endtask

   task automatic t_reset_partial();
      rst_n = 1'b0;
      pulse(2'b11, 2'b00);
      rst_n = 1'b1;
      ba_oe_n = 2'b10; #1;
      chk("R8 clocked register cleared", b_bus, 16'h0000);
      chk("R8 unclocked register kept", a_out[7:0], 8'h77);
   endtask

   initial begin
      #20;
      t_reset();
      t_load_ab();
      t_hold_ab();
      t_hiz();
      t_keeper_b();
      t_load_ba();
      t_contend();
      t_full_width();
      t_keeper_a();
      t_reset_partial();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule